// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the refresh and start-up duties of an asynchronous, multiplexed-address DRAM. After reset it keeps the strobes idle for a power-up pause and then runs a fixed number of initialization cycles, all of them CAS-before-RAS refreshes. It then refreshes the array at a steady rate derived from the retention period and the row count. Because the device generates the row address itself, the block never drives the address pins.

A host access controller shares the RAS, CAS and W pins with the sequencer. The host raises a request for as long as it holds the pins, and the sequencer answers with a grant. The sequencer takes the pins only while the host request is low. Refresh ticks that arrive while the host is busy are counted up to a ceiling. When the count reaches that ceiling, the grant is withdrawn until the backlog has been drained.

On a self-refresh request the block lowers CAS and then RAS, and holds both low for at least a minimum time and for as long as the request stays high. On exit it raises both strobes and then runs a burst of refreshes over every row before the host may use the pins again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low, ras_n_o, cas_n_o and we_n_o are 1, own_o is 1, phase_o is 0 and host_gnt_o is 0, whatever host_req_i is.
- R2: After reset is released, both strobes stay high for PWRUP_CYC cycles. CAS first goes low in clock cycle PWRUP_CYC+1, counting the first rising edge after reset release as cycle 1.
- R3: Every refresh has the same shape. CAS falls T_CSR cycles before RAS. RAS then stays low for T_RAS cycles while CAS stays low. Both strobes then stay high for T_RP cycles. we_n_o is 1 throughout.
- R4: Exactly INIT_CYCLES refreshes happen while phase_o is 0. After the last of them, phase_o becomes 1.
- R5: While phase_o is 1, one refresh request arises every RETENTION_CYC/ROWS cycles, counted from the first normal cycle. With the host idle, each request starts its refresh in the cycle after it arises.
- R6: Requests that cannot be served are counted, up to MAX_PEND. When host_req_i falls, the stored requests are served back to back, each starting one cycle after the previous one ends.
- R7: host_gnt_o is 1 only when host_req_i is 1, phase_o is 1, no refresh is under way and fewer than MAX_PEND requests are stored. own_o is 1 whenever the sequencer is not idle in the normal phase. No refresh starts while host_req_i is 1.
- R8: When sr_req_i is high in the idle normal state with nothing stored, the block enters self refresh (phase_o = 2). CAS falls, then RAS falls T_CSR cycles later. RAS stays low for at least SR_MIN_CYC+1 cycles and until sr_req_i is seen low.
- R9: On leaving self refresh, phase_o becomes 3 and ROWS refreshes follow, during which host_gnt_o stays 0. phase_o then returns to 1 with the stored-request count cleared and the interval restarted from zero.
- R10: phase_o encodes 0 = initializing, 1 = normal, 2 = self refresh, 3 = burst after self refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host wants, or is holding, the DRAM pins |
| sr_req_i | input | 1 | Level request to enter and stay in self refresh |
| host_gnt_o | output | 1 | Host may drive the DRAM pins |
| own_o | output | 1 | Sequencer drives RAS, CAS and W |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high for refresh |
| phase_o | output | 2 | Phase code as in R10 |

## Verification
Assertions check every cycle that each RAS fall is preceded by CAS low, that the grant is given only while both strobes are idle, and that the strobes stay quiet during the power-up pause. They also check that the stored-request count never passes its ceiling, that a self-refresh RAS rise never comes before the minimum low time, and that the burst phase can only return to normal. The bench's scenarios are needed to show the counts and spacing that depend on history. These are: the number of initialization refreshes; the first CAS fall after the pause; the refresh spacing in normal operation; the drain of a saturated backlog after a long host hold; the exact self-refresh low lengths for a short and a long request; and a burst that covers every row.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {
    PH_INIT   = 2'd0,
    PH_NORMAL = 2'd1,
    PH_SELF   = 2'd2,
    PH_BURST  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {E_IDLE, E_LEAD, E_LOW, E_PRE} eng_e;

  typedef enum logic [2:0] {S_PWRUP, S_INIT, S_IDLE, S_REF, S_SR, S_BURST} seq_e;
endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int unsigned INTERVAL = 3906,
  parameter int unsigned MAX_PEND = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic take_i,
  output logic any_o,
  output logic full_o
);
  localparam int unsigned TW = $clog2(INTERVAL);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);

  logic [TW-1:0] tmr_q;
  logic [PW-1:0] pend_q;
  logic          tick;

  assign tick   = en_i && (tmr_q == TW'(INTERVAL - 1));
  assign any_o  = pend_q != '0;
  assign full_o = pend_q == PW'(MAX_PEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_q <= '0;
    end else if (!en_i) begin
      tmr_q  <= '0;
      pend_q <= '0;
    end else begin
      tmr_q <= tick ? '0 : tmr_q + 1'b1;
      unique case ({tick, take_i})
        2'b10:   if (!full_o) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  AST_PEND_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PW'(MAX_PEND)) else $error("pending above ceiling"); // R6
  AST_TAKE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> any_o) else $error("take with nothing stored"); // R6
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && full_o && !take_i) |=> full_o) else $error("saturated count dropped"); // R6
endmodule

// File: rtl/cbr_engine.sv
module cbr_engine
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned T_CSR = 2,
  parameter int unsigned T_RAS = 15,
  parameter int unsigned T_RP  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  output logic busy_o,
  output logic done_o,
  output logic low_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned T_A   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int unsigned T_MAX = (T_A > T_RP) ? T_A : T_RP;
  localparam int unsigned CW    = $clog2(T_MAX + 1);

  eng_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= E_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        E_IDLE: if (start_i) begin
          st_q  <= E_LEAD;
          cnt_q <= '0;
        end
        E_LEAD: if (cnt_q == CW'(T_CSR - 1)) begin
          st_q  <= E_LOW;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        E_LOW: if (cnt_q >= CW'(T_RAS - 1) && !hold_i) begin
          st_q  <= E_PRE;
          cnt_q <= '0;
        end else if (cnt_q < CW'(T_RAS - 1)) cnt_q <= cnt_q + 1'b1;
        E_PRE: if (cnt_q == CW'(T_RP - 1)) begin
          st_q  <= E_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign busy_o  = st_q != E_IDLE;
  assign done_o  = (st_q == E_PRE) && (cnt_q == CW'(T_RP - 1));
  assign low_o   = st_q == E_LOW;
  assign ras_n_o = !low_o;
  assign cas_n_o = !((st_q == E_LEAD) || (st_q == E_LOW));

  AST_CBR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o)) else $error("RAS fell without CAS lead"); // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o) else $error("start while busy"); // R3
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned PWRUP_CYC     = 50000,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned ROWS          = 1024,
  parameter int unsigned RETENTION_CYC = 4000000,
  parameter int unsigned MAX_PEND      = 4,
  parameter int unsigned SR_MIN_CYC    = 25000,
  parameter int unsigned T_CSR         = 2,
  parameter int unsigned T_RAS         = 15,
  parameter int unsigned T_RP          = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_req_i,
  input  logic       sr_req_i,
  output logic       host_gnt_o,
  output logic       own_o,
  output logic       ras_n_o,
  output logic       cas_n_o,
  output logic       we_n_o,
  output logic [1:0] phase_o
);
  localparam int unsigned INTERVAL = RETENTION_CYC / ROWS;
  localparam int unsigned WMAX     = (PWRUP_CYC > SR_MIN_CYC) ? PWRUP_CYC : SR_MIN_CYC;
  localparam int unsigned WW       = $clog2(WMAX + 1);
  localparam int unsigned RMAX     = (ROWS > INIT_CYCLES) ? ROWS : INIT_CYCLES;
  localparam int unsigned RW       = $clog2(RMAX + 1);

  seq_e          st_q;
  logic [WW-1:0] wait_q;
  logic [RW-1:0] ref_q;
  logic eng_start, eng_hold, eng_busy, eng_done, eng_low;
  logic pend_any, pend_full, take, tmr_en;
  phase_e phase;

  always_comb begin
    eng_start = 1'b0;
    unique case (st_q)
      S_INIT, S_BURST: eng_start = !eng_busy;
      S_IDLE:          eng_start = !host_req_i && (pend_any || sr_req_i);
      default:         eng_start = 1'b0;
    endcase
  end

  assign take     = (st_q == S_IDLE) && !host_req_i && pend_any;
  assign eng_hold = (st_q == S_SR) && (sr_req_i || (wait_q < WW'(SR_MIN_CYC)));
  assign tmr_en   = (st_q == S_IDLE) || (st_q == S_REF);

  always_comb begin
    unique case (st_q)
      S_IDLE, S_REF: phase = PH_NORMAL;
      S_SR:          phase = PH_SELF;
      S_BURST:       phase = PH_BURST;
      default:       phase = PH_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_PWRUP;
      wait_q <= '0;
      ref_q  <= '0;
    end else begin
      unique case (st_q)
        S_PWRUP: if (wait_q == WW'(PWRUP_CYC - 1)) begin
          st_q   <= S_INIT;
          wait_q <= '0;
        end else wait_q <= wait_q + 1'b1;
        S_INIT: if (eng_done) begin
          if (ref_q == RW'(INIT_CYCLES - 1)) begin
            st_q  <= S_IDLE;
            ref_q <= '0;
          end else ref_q <= ref_q + 1'b1;
        end
        S_IDLE: if (take) st_q <= S_REF;
        else if (eng_start) begin
          st_q   <= S_SR;
          wait_q <= '0;
        end
        S_REF: if (eng_done) st_q <= S_IDLE;
        S_SR: begin
          if (eng_low && (wait_q < WW'(SR_MIN_CYC))) wait_q <= wait_q + 1'b1;
          if (eng_done) begin
            st_q  <= S_BURST;
            ref_q <= '0;
          end
        end
        S_BURST: if (eng_done) begin
          if (ref_q == RW'(ROWS - 1)) begin
            st_q  <= S_IDLE;
            ref_q <= '0;
          end else ref_q <= ref_q + 1'b1;
        end
        default: st_q <= S_PWRUP;
      endcase
    end
  end

  rfsh_interval #(
    .INTERVAL(INTERVAL),
    .MAX_PEND(MAX_PEND)
  ) u_interval (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tmr_en),
    .take_i(take),
    .any_o (pend_any),
    .full_o(pend_full)
  );

  cbr_engine #(
    .T_CSR(T_CSR),
    .T_RAS(T_RAS),
    .T_RP (T_RP)
  ) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .hold_i (eng_hold),
    .busy_o (eng_busy),
    .done_o (eng_done),
    .low_o  (eng_low),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o)
  );

  assign host_gnt_o = host_req_i && (st_q == S_IDLE) && !pend_full;
  assign own_o      = st_q != S_IDLE;
  assign we_n_o     = 1'b1;
  assign phase_o    = phase;

  AST_GNT_PINS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> (ras_n_o && cas_n_o)) else $error("grant with strobes active"); // R7
  AST_PWRUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PWRUP) |-> (ras_n_o && cas_n_o)) else $error("strobe during pause"); // R2
  AST_SR_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_SR) && $rose(ras_n_o)) |-> (wait_q == WW'(SR_MIN_CYC)))
    else $error("self refresh too short"); // R8
  AST_BURST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_BURST) |=> (phase == PH_BURST || phase == PH_NORMAL))
    else $error("bad exit from burst"); // R9
endmodule

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
  localparam int PWRUP = 20, INIT = 8, ROWS = 16, RET = 640, MAXP = 3;
  localparam int SRMIN = 30, TCSR = 2, TRAS = 3, TRP = 2;
  localparam int IVL = RET / ROWS;

  logic clk = 1'b0, rst_n = 1'b0, host_req = 1'b0, sr_req = 1'b0;
  logic gnt, own, ras_n, cas_n, we_n;
  logic [1:0] phase;

  dram_refresh_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CYCLES(INIT), .ROWS(ROWS), .RETENTION_CYC(RET),
    .MAX_PEND(MAXP), .SR_MIN_CYC(SRMIN), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .sr_req_i(sr_req),
    .host_gnt_o(gnt), .own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .phase_o(phase)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: md 0 pause,1 init,2 idle,3 refresh,4 self,5 burst; es 0 idle,1 lead,2 low,3 pre
  int md, wc, rc, pd, tc, es, ec;
  task automatic step();
    int nmd = md, nwc = wc, nrc = rc, npd = pd, ntc = tc, nes = es, nec = ec;
    bit done = (es == 3) && (ec == TRP - 1);
    bit take = (md == 2) && !host_req && (pd > 0);
    bit hold = (md == 4) && (sr_req || wc < SRMIN);
    bit start = ((md == 1 || md == 5) && es == 0) || ((md == 2) && !host_req && (pd > 0 || sr_req));
    bit tick;
    case (es)
      0: if (start) begin nes = 1; nec = 0; end
      1: if (ec == TCSR - 1) begin nes = 2; nec = 0; end else nec = ec + 1;
      2: if (ec >= TRAS - 1 && !hold) begin nes = 3; nec = 0; end
         else if (ec < TRAS - 1) nec = ec + 1;
      default: if (ec == TRP - 1) begin nes = 0; nec = 0; end else nec = ec + 1;
    endcase
    if (md == 2 || md == 3) begin
      tick = (tc == IVL - 1);
      ntc = tick ? 0 : tc + 1;
      if (tick && !take && pd < MAXP) npd = pd + 1;
      else if (take && !tick) npd = pd - 1;
    end else begin
      ntc = 0; npd = 0;
    end
    case (md)
      0: if (wc == PWRUP - 1) begin nmd = 1; nwc = 0; end else nwc = wc + 1;
      1: if (done) begin if (rc == INIT - 1) begin nmd = 2; nrc = 0; end else nrc = rc + 1; end
      2: if (take) nmd = 3; else if (start) begin nmd = 4; nwc = 0; end
      3: if (done) nmd = 2;
      4: begin
        if (es == 2 && wc < SRMIN) nwc = wc + 1;
        if (done) begin nmd = 5; nrc = 0; end
      end
      default: if (done) begin if (rc == ROWS - 1) begin nmd = 2; nrc = 0; end else nrc = rc + 1; end
    endcase
    md = nmd; wc = nwc; rc = nrc; pd = npd; tc = ntc; es = nes; ec = nec;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin md = 0; wc = 0; rc = 0; pd = 0; tc = 0; es = 0; ec = 0; end
    else step();
  end

  // per-cycle comparison and event monitors
  int cyc = 0, first_cas = -1, run = 0, last_low = 0;
  int falls [4] = '{0, 0, 0, 0};
  logic prev_ras = 1'b1;
  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      int eph;
      eph = (md <= 1) ? 0 : (md <= 3) ? 1 : (md == 4) ? 2 : 3;
      chk(ras_n == (es != 2), "R3 ras_n", ras_n, es != 2);
      chk(cas_n == !(es == 1 || es == 2), "R3 cas_n", cas_n, !(es == 1 || es == 2));
      chk(we_n == 1'b1, "R3 we_n", we_n, 1);
      chk(int'(phase) == eph, "R10 phase", phase, eph);
      chk(gnt == (host_req && md == 2 && pd < MAXP), "R7 gnt", gnt, host_req && md == 2 && pd < MAXP);
      chk(own == (md != 2), "R7 own", own, md != 2);
      if (first_cas < 0 && !cas_n) first_cas = cyc;
      if (prev_ras && !ras_n) falls[phase]++;
      prev_ras = ras_n;
      if (!ras_n && phase == 2'd2) run++;
      else if (run != 0) begin last_low = run; run = 0; end
    end
  end

  task automatic pwait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wait_phase(input int p);
    do begin @(negedge clk); #1; end while (int'(phase) != p);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int snap;
    host_req = 1'b1;
    pwait(3);
    // R1: reset state
    chk(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
    chk(phase == 2'd0, "R1 phase", phase, 0);
    chk(gnt == 1'b0, "R1 gnt", gnt, 0);
    chk(own == 1'b1, "R1 own", own, 1);
    host_req = 1'b0;
    rst_n = 1'b1;

    wait_phase(1);
    chk(first_cas == PWRUP + 1, "R2 first CAS cycle", first_cas, PWRUP + 1);
    chk(falls[0] == INIT, "R4 init refreshes", falls[0], INIT);

    // R5: spacing over ten intervals from the first normal cycle
    snap = falls[1];
    repeat (400) @(negedge clk);
    #1;
    chk(falls[1] - snap == 9, "R5 refreshes in window", falls[1] - snap, 9);

    // R6/R7: long host hold saturates the backlog
    pwait(1);
    host_req = 1'b1;
    pwait(20);
    snap = falls[1];
    pwait(180);
    chk(falls[1] - snap == 0, "R7 no refresh under host", falls[1] - snap, 0);
    chk(gnt == 1'b0, "R6 grant withdrawn when full", gnt, 0);
    host_req = 1'b0;
    snap = falls[1];
    repeat (26) @(negedge clk);
    #1;
    chk(falls[1] - snap == MAXP, "R6 backlog drained", falls[1] - snap, MAXP);

    // R8: short request, minimum low time applies
    pwait(1);
    sr_req = 1'b1;
    wait_phase(2);
    pwait(1);
    sr_req = 1'b0;
    snap = falls[3];
    wait_phase(3);
    chk(last_low == SRMIN + 1, "R8 minimum self-refresh low", last_low, SRMIN + 1);
    pwait(1);
    host_req = 1'b1;
    #1;
    chk(gnt == 1'b0, "R9 no grant in burst", gnt, 0);
    pwait(2);
    host_req = 1'b0;
    wait_phase(1);
    chk(falls[3] - snap == ROWS, "R9 burst covers rows", falls[3] - snap, ROWS);

    // R9: interval restarts at zero after the burst
    snap = falls[1];
    repeat (42) @(negedge clk);
    #1;
    chk(falls[1] - snap == 0, "R9 no early refresh", falls[1] - snap, 0);
    @(negedge clk);
    #1;
    chk(falls[1] - snap == 1, "R9 first refresh after restart", falls[1] - snap, 1);

    // R8: long request, low time follows the request
    pwait(10);
    sr_req = 1'b1;
    wait_phase(2);
    pwait(100);
    sr_req = 1'b0;
    snap = falls[3];
    wait_phase(3);
    chk(last_low == 99, "R8 long self-refresh low", last_low, 99);
    wait_phase(1);
    chk(falls[3] - snap == ROWS, "R9 second burst", falls[3] - snap, ROWS);

    pwait(5);
    finish_run();
  end
endmodule